// File: doc/BRIEF.md
# Two-Rank Converter Code Register

This block stores the input word of a digital-to-analog converter in two ranks of level-sensitive storage. Each rank is modelled on a system clock. A parallel bus writes the front rank while an active-low select and an active-low load strobe are both low. An active-high transfer strobe copies the front rank into the back rank, and the back rank drives the converter code. The transfer strobe ignores the select, so many instances on one board can share one strobe and change their outputs on the same clock edge.

A "transparent" rank updates on every clock edge while its enable condition holds. The back rank reads a combined view of the front rank: the live bus word while the front rank is open, and the stored word otherwise. When both ranks are open, bus data reaches the output one edge later. When select is tied to the transfer strobe and load is held low, the block behaves like an edge-triggered register.

A monitor counts clock edges since the front rank last closed. It raises a one-cycle warning when the transfer strobe rises too soon after that close, which enforces the spacing that limits bit skew.

Top module: `dbuf_dac_reg`

## Requirements
- R1: On a clock edge where `sel_n`=0 and `load_n`=0, the front rank stores `bus_data`.
- R2: On a clock edge where `sel_n`=1 or `load_n`=1, the front rank keeps its value, whatever `bus_data` carries.
- R3: On a clock edge where `xfer`=1, `code_out` takes the front-rank view, whatever the value of `sel_n`. The front-rank view is `bus_data` if the front rank is open on that edge and the stored front word otherwise.
- R4: On a clock edge where `xfer`=0, `code_out` keeps its value.
- R5: With `sel_n`=0, `load_n`=0 and `xfer`=1, `code_out` equals the `bus_data` sampled on the previous edge.
- R6: With `sel_n` driven the same as `xfer` and `load_n`=0, each rising edge of the pair sets `code_out` to the bus word loaded just before that rise. `code_out` holds while the pair is low.
- R7: A clock edge with `rst`=1 clears both ranks. After that edge `code_out`=0 and `early_xfer`=0.
- R8: An edge that samples `xfer`=1 after `xfer`=0, with fewer than `SKEW_CYC` edges sampling the front rank closed since it was last open, sets `early_xfer` high. `early_xfer` stays high for exactly one cycle after that edge.
- R9: `early_xfer` stays low in three cases. The rise comes `SKEW_CYC` or more closed edges after the last load. No load has happened since reset. `xfer` stays high with no new rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling every control |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 16 | Parallel data word, straight binary |
| sel_n | input | 1 | Active-low chip select for the front rank |
| load_n | input | 1 | Active-low front-rank load strobe |
| xfer | input | 1 | Active-high transfer strobe for the back rank, ungated |
| code_out | output | 16 | Converter code, driven by the back rank |
| early_xfer | output | 1 | One-cycle warning of a premature transfer |

## Verification
The front rank has no port of its own. A wrong front word therefore shows up only at `code_out`, one edge after the next transfer. The bench follows every hold period with a transfer that exposes the stored word. A back rank that updates when it should hold shows a wrong `code_out` on the very next edge. A faulty gap counter shows up as a wrong `early_xfer` on the edge that samples the rise. The bench probes gaps on both sides of the limit for that reason.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    parameter int unsigned DEF_WORD_W   = 16;
    parameter int unsigned DEF_SKEW_CYC = 4;

    // Control pins as sampled on one clock edge
    typedef struct packed {
        logic sel_n;
        logic load_n;
        logic xfer;
    } ctl_t;

    // Which source the back rank sees this edge
    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_STORED  = 2'd1,
        SRC_THROUGH = 2'd2
    } back_src_t;

    function automatic logic front_is_open(ctl_t c);
        return (!c.sel_n) && (!c.load_n);
    endfunction

    function automatic back_src_t pick_src(ctl_t c);
        if (!c.xfer)          return SRC_HOLD;
        if (front_is_open(c)) return SRC_THROUGH;
        return SRC_STORED;
    endfunction

endpackage

// File: rtl/dbuf_front_rank.sv
module dbuf_front_rank
    import dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] bus_data,
    output logic              open_o,
    output logic [DATA_W-1:0] view_o
);
    logic [DATA_W-1:0] word_q;

    assign open_o = front_is_open(ctl);
    assign view_o = open_o ? bus_data : word_q;

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (open_o) word_q <= bus_data;
    end

    a_r1_front_load: assert property (@(posedge clk) disable iff (rst)
        open_o |=> word_q == $past(bus_data));
    a_r2_front_hold: assert property (@(posedge clk) disable iff (rst)
        !open_o |=> $stable(word_q));

endmodule

// File: rtl/dbuf_back_rank.sv
module dbuf_back_rank
    import dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  back_src_t         src,
    input  logic [DATA_W-1:0] view_i,
    output logic [DATA_W-1:0] code_o
);
    logic [DATA_W-1:0] code_q;
    logic              rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        if (rst)                  code_q <= '0;
        else if (src != SRC_HOLD) code_q <= view_i;
    end

    always_ff @(posedge clk) rst_seen <= rst;

    assign code_o = code_q;

    always @(negedge clk) begin
        if (rst_seen) a_r7_reset_zero: assert (code_q == '0);
    end

    a_r3_back_follow: assert property (@(posedge clk) disable iff (rst)
        (src != SRC_HOLD) |=> code_q == $past(view_i));
    a_r4_back_hold: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOLD) |=> $stable(code_q));

endmodule

// File: rtl/dbuf_skew_monitor.sv
module dbuf_skew_monitor
    import dbuf_pkg::*;
#(
    parameter int unsigned SKEW_CYC = DEF_SKEW_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic xfer_i,
    output logic early_o
);
    localparam int unsigned CNT_W = $clog2(SKEW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SKEW_CYC);

    logic [CNT_W-1:0] gap_q;
    logic             xfer_d;
    logic             early_q;
    logic             rise;

    assign rise = xfer_i && !xfer_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= CNT_MAX;
            xfer_d  <= 1'b0;
            early_q <= 1'b0;
        end else begin
            xfer_d  <= xfer_i;
            early_q <= rise && (gap_q < CNT_MAX);
            if (open_i)              gap_q <= '0;
            else if (gap_q < CNT_MAX) gap_q <= gap_q + 1'b1;
        end
    end

    assign early_o = early_q;

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        early_q |=> !early_q);
    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        early_q |-> $past(xfer_i));
    a_r9_gap_bounded: assert property (@(posedge clk) disable iff (rst)
        gap_q <= CNT_MAX);

endmodule

// File: rtl/dbuf_dac_reg.sv
module dbuf_dac_reg
    import dbuf_pkg::*;
#(
    parameter int unsigned DATA_W   = DEF_WORD_W,
    parameter int unsigned SKEW_CYC = DEF_SKEW_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              sel_n,
    input  logic              load_n,
    input  logic              xfer,
    output logic [DATA_W-1:0] code_out,
    output logic              early_xfer
);
    ctl_t              ctl;
    back_src_t         src;
    logic              front_open;
    logic [DATA_W-1:0] front_view;

    assign ctl = '{sel_n: sel_n, load_n: load_n, xfer: xfer};
    assign src = pick_src(ctl);

    dbuf_front_rank #(.DATA_W(DATA_W)) u_front (
        .clk(clk), .rst(rst), .ctl(ctl), .bus_data(bus_data),
        .open_o(front_open), .view_o(front_view)
    );

    dbuf_back_rank #(.DATA_W(DATA_W)) u_back (
        .clk(clk), .rst(rst), .src(src), .view_i(front_view),
        .code_o(code_out)
    );

    dbuf_skew_monitor #(.SKEW_CYC(SKEW_CYC)) u_mon (
        .clk(clk), .rst(rst), .open_i(front_open), .xfer_i(xfer),
        .early_o(early_xfer)
    );

    // R5: both ranks open -> output is last edge's bus word
    a_r5_through: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !load_n && xfer) |=> code_out == $past(bus_data));

endmodule

// File: tb/dbuf_dac_reg_bench.sv
module dbuf_dac_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_data;
    logic        sel_n, load_n, xfer;
    logic [15:0] code_out;
    logic        early_xfer;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 0;

    always #2.5 clk = ~clk;

    dbuf_dac_reg u_dbuf_dac_reg (
        .clk(clk), .rst(rst), .bus_data(bus_data), .sel_n(sel_n),
        .load_n(load_n), .xfer(xfer), .code_out(code_out),
        .early_xfer(early_xfer)
    );

    typedef struct packed {
        logic        s_n;
        logic        l_n;
        logic        x;
        logic [15:0] d;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000},  // R1 load, R4 hold
        '{1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000},  // R2
        '{1'b1, 1'b1, 1'b1, 16'hAAAA, 16'h1234},  // R3 ungated xfer, R2
        '{1'b0, 1'b1, 1'b0, 16'h5555, 16'h1234},  // R2 R4
        '{1'b0, 1'b0, 1'b0, 16'h8000, 16'h1234},  // R1 R4
        '{1'b1, 1'b0, 1'b0, 16'h7FFF, 16'h1234},  // R4
        '{1'b1, 1'b0, 1'b1, 16'h0000, 16'h8000},  // R3
        '{1'b0, 1'b0, 1'b1, 16'hBEEF, 16'hBEEF},  // R5
        '{1'b0, 1'b0, 1'b1, 16'h0001, 16'h0001},  // R5
        '{1'b1, 1'b1, 1'b0, 16'h9999, 16'h0001},  // R4
        '{1'b1, 1'b1, 1'b1, 16'h2222, 16'h0001}   // R2 front kept 0001
    };

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; sel_n = 1'b1; load_n = 1'b1; xfer = 1'b0; bus_data = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic skew_probe(int gap, logic exp_flag, string tag);
        sel_n = 1'b0; load_n = 1'b0; xfer = 1'b0; bus_data = 16'h0F0F;
        step(1);
        sel_n = 1'b1;
        step(gap);
        xfer = 1'b1;
        step(1);
        chk(tag, {15'b0, early_xfer}, {15'b0, exp_flag});
        xfer = 1'b0;
        step(1);
    endtask

    initial begin
        do_reset();
        step(1);
        chk("R7 code after reset", code_out, 16'h0000);
        chk("R7 flag after reset", {15'b0, early_xfer}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            sel_n = VECS[i].s_n; load_n = VECS[i].l_n;
            xfer = VECS[i].x; bus_data = VECS[i].d;
            step(1);
            chk($sformatf("R1-table vec %0d", i), code_out, VECS[i].exp);
        end

        // R6 edge-style mode: sel_n follows xfer, load_n low
        do_reset();
        load_n = 1'b0; sel_n = 1'b0; xfer = 1'b0; bus_data = 16'hA1A1;
        step(2);
        chk("R6 hold while pair low", code_out, 16'h0000);
        sel_n = 1'b1; xfer = 1'b1; bus_data = 16'hB2B2;
        step(1);
        chk("R6 first rising pair", code_out, 16'hA1A1);
        chk("R8 early on joined edge", {15'b0, early_xfer}, 16'h0001);
        step(1);
        chk("R8 pulse lasts one cycle", {15'b0, early_xfer}, 16'h0000);
        sel_n = 1'b0; xfer = 1'b0; bus_data = 16'hC3C3;
        step(2);
        chk("R6 holds after fall", code_out, 16'hA1A1);
        sel_n = 1'b1; xfer = 1'b1; bus_data = 16'hD4D4;
        step(1);
        chk("R6 second rising pair", code_out, 16'hC3C3);

        // Skew monitor (default SKEW_CYC = 4)
        do_reset();
        xfer = 1'b1;
        step(1);
        chk("R9 no load since reset", {15'b0, early_xfer}, 16'h0000);
        xfer = 1'b0;
        step(1);
        skew_probe(3, 1'b1, "R8 gap 3 flagged");
        skew_probe(4, 1'b0, "R9 gap 4 quiet");
        skew_probe(1, 1'b1, "R8 gap 1 flagged");
        sel_n = 1'b1; xfer = 1'b1;
        step(1);
        step(1);
        chk("R9 held strobe no pulse", {15'b0, early_xfer}, 16'h0000);
        xfer = 1'b0;
        step(1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule